// File: doc/BRIEF.md
# Strobed Input Channel with Handshake

This block is one 8-bit input channel of a parallel peripheral port that uses a handshake. The peripheral puts a byte on the port pins and pulses an active-low strobe. The falling edge of the strobe, once brought into the clock domain, loads the pins into an input latch and raises a buffer-full flag. When the strobe returns high while the buffer is still full, the channel raises an interrupt request, but only if its interrupt-enable flip-flop is set.

The host reads the latched byte with a one-cycle read pulse. The read clears both the buffer-full flag and the interrupt request. The enable flip-flop is written by a set/reset command aimed at one bit of port C. The channel also presents its buffer-full, enable and interrupt states as a port C status byte the host can poll. Address decode and mode selection are outside the block: the read pulse and the set/reset command arrive as plain control inputs.

The strobe and the pins each pass through a synchroniser chain with a parameterised number of stages. A parameter selects which channel the block is, and that choice sets both the port C control bit and the status bit positions.

Top module: `strb_in_chan`

## Requirements
- R1: While reset is high and after its release, the latch reads 0, buffer-full, interrupt request and enable are 0, and the status byte is 0.
- R2: A falling edge of `stb_n` loads the synchronised pins into the latch. With the default two synchroniser stages, the new byte is visible on `rx_data` after the third rising clock edge from the edge that first samples the low strobe.
- R3: `ibf` rises in the same cycle as the new latch data and not before.
- R4: With the enable set and the buffer full, `intr` rises on the third rising edge after `stb_n` returns high. It is still 0 after the second edge.
- R5: While the enable flip-flop is clear, `intr` stays 0 even with the buffer full and the strobe high.
- R6: A one-cycle `host_rd` pulse clears `ibf` and `intr` at the next edge and leaves `rx_data` unchanged.
- R7: A set/reset command (`bsr_we` high) loads `bsr_val` into the enable flip-flop only when `bsr_sel` equals the channel's control bit: 4 for channel A (`CHAN_B`=0), 2 for channel B. Any other bit number leaves the enable unchanged.
- R8: A strobe that arrives while the buffer is already full reloads the latch with the new byte, and `ibf` stays 1.
- R9: In the status byte, channel A places buffer-full at bit 5, enable at bit 4 and interrupt at bit 3. Channel B places enable at bit 2, buffer-full at bit 1 and interrupt at bit 0. All other bits are 0.
- R10: If a host read and a strobe capture land in the same cycle, the capture wins: `ibf` stays 1 and the latch takes the new byte.
- R11: Pin changes while the strobe is held low or held high do not alter the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| pins | input | WIDTH | Peripheral data pins, asynchronous |
| host_rd | input | 1 | One-cycle host read of the data port |
| bsr_we | input | 1 | Port C bit set/reset command valid |
| bsr_sel | input | 3 | Port C bit number addressed by the command |
| bsr_val | input | 1 | 1 sets the addressed bit, 0 clears it |
| rx_data | output | WIDTH | Latched input byte |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Interrupt request |
| inte | output | 1 | Interrupt-enable flip-flop state |
| status | output | 8 | Port C status byte for this channel |

## Verification
A wrong internal state shows at the ports within a few cycles. A missed or doubled edge detect leaves `ibf` low, or raises it with the wrong byte, exactly three edges after the strobe. A stale enable flip-flop appears as a wrong bit in `status` one edge after the command. An interrupt that ignores the strobe level rises too early, or never, at the third edge after the strobe returns high. A faulty clear on read leaves `ibf` or `intr` set one edge after the read pulse. The bench therefore samples these outputs at the exact edges named in the requirements, rather than after loose waits.

// File: rtl/strb_in_pkg.sv
package strb_in_pkg;

   localparam int STAT_W = 8;
   localparam int SEL_W  = 3;

   // port C bit that carries the enable command for each channel
   function automatic int ctrl_bit(input int chan_b);
      return (chan_b != 0) ? 2 : 4;
   endfunction

   typedef struct packed {
      logic full;
      logic enable;
      logic irq;
   } hs_state_t;

endpackage

// File: rtl/strb_sync.sv
module strb_sync #(
   parameter int         WIDTH   = 1,
   parameter int         STAGES  = 2,
   parameter logic [0:0] RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);

   localparam logic [WIDTH-1:0] INIT = {WIDTH{RST_VAL}};

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("strb_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("strb_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) chain_q[0] <= INIT;
      else     chain_q[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain_q[s] <= INIT;
            else     chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/strb_edge.sv
module strb_edge (
   input  logic clk,
   input  logic rst,
   input  logic stb_s,
   output logic fall,
   output logic level_hi
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b1;
      else     prev_q <= stb_s;
   end

   assign fall     = prev_q & ~stb_s;
   assign level_hi = stb_s;

   // R11
   fall_single_chk: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall);

endmodule

// File: rtl/strb_hs_core.sv
module strb_hs_core
   import strb_in_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int CTRL_BIT = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             fall,
   input  logic             level_hi,
   input  logic [WIDTH-1:0] pins_s,
   input  logic             host_rd,
   input  logic             bsr_we,
   input  logic [SEL_W-1:0] bsr_sel,
   input  logic             bsr_val,
   output logic [WIDTH-1:0] data_q,
   output hs_state_t        st
);

   localparam logic [SEL_W-1:0] SEL_HIT = SEL_W'(CTRL_BIT);

   generate
      if (CTRL_BIT < 0 || CTRL_BIT > 7) begin : g_bad_bit
         $error("strb_hs_core: CTRL_BIT out of range");
      end
   endgenerate

   logic ibf_q, inte_q, intr_q;
   logic sel_hit;

   assign sel_hit = bsr_we && (bsr_sel == SEL_HIT);

   always_ff @(posedge clk) begin
      if (rst) begin
         inte_q <= 1'b0;
      end else if (sel_hit) begin
         inte_q <= bsr_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q <= '0;
         ibf_q  <= 1'b0;
      end else if (fall) begin
         data_q <= pins_s;
         ibf_q  <= 1'b1;
      end else if (host_rd) begin
         ibf_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) intr_q <= 1'b0;
      else     intr_q <= !host_rd && ibf_q && inte_q && level_hi;
   end

   assign st.full   = ibf_q;
   assign st.enable = inte_q;
   assign st.irq    = intr_q;

   // R5
   intr_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
      !inte_q |=> !intr_q);

   // R4
   intr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
      intr_q |-> ibf_q);

   // R2
   capture_data_chk: assert property (@(posedge clk) disable iff (rst)
      fall |=> (ibf_q && data_q == $past(pins_s)));

   // R6
   read_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (host_rd && !fall) |=> (!ibf_q && !intr_q && $stable(data_q)));

   // R7
   bsr_other_bit_chk: assert property (@(posedge clk) disable iff (rst)
      (bsr_we && bsr_sel != SEL_HIT) |=> $stable(inte_q));

   // R11
   hold_latch_chk: assert property (@(posedge clk) disable iff (rst)
      !fall |=> $stable(data_q));

endmodule

// File: rtl/strb_in_chan.sv
module strb_in_chan
   import strb_in_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CHAN_B      = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stb_n,
   input  logic [WIDTH-1:0]   pins,
   input  logic               host_rd,
   input  logic               bsr_we,
   input  logic [SEL_W-1:0]   bsr_sel,
   input  logic               bsr_val,
   output logic [WIDTH-1:0]   rx_data,
   output logic               ibf,
   output logic               intr,
   output logic               inte,
   output logic [STAT_W-1:0]  status
);

   localparam int CTRL_BIT = ctrl_bit(CHAN_B);

   logic             stb_s;
   logic [WIDTH-1:0] pins_s;
   logic             fall, level_hi;
   hs_state_t        st;

   strb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_stb_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (stb_n),
      .d_sync  (stb_s)
   );

   strb_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (pins),
      .d_sync  (pins_s)
   );

   strb_edge u_edge (
      .clk      (clk),
      .rst      (rst),
      .stb_s    (stb_s),
      .fall     (fall),
      .level_hi (level_hi)
   );

   strb_hs_core #(.WIDTH(WIDTH), .CTRL_BIT(CTRL_BIT)) u_core (
      .clk      (clk),
      .rst      (rst),
      .fall     (fall),
      .level_hi (level_hi),
      .pins_s   (pins_s),
      .host_rd  (host_rd),
      .bsr_we   (bsr_we),
      .bsr_sel  (bsr_sel),
      .bsr_val  (bsr_val),
      .data_q   (rx_data),
      .st       (st)
   );

   assign ibf  = st.full;
   assign intr = st.irq;
   assign inte = st.enable;

   generate
      if (CHAN_B != 0) begin : g_stat_b
         assign status = {5'b00000, st.enable, st.full, st.irq};
      end else begin : g_stat_a
         assign status = {2'b00, st.full, st.enable, st.irq, 3'b000};
      end
   endgenerate

   // R9
   status_count_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(status) == ($countones({ibf, inte, intr})));

endmodule

// File: tb/strb_in_chan_test.sv
`timescale 1ns/100ps
module strb_in_chan_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       stb_n = 1'b1;
   logic [7:0] pins = 8'h00;
   logic       host_rd = 1'b0;
   logic       bsr_we = 1'b0;
   logic [2:0] bsr_sel = 3'd0;
   logic       bsr_val = 1'b0;
   logic [7:0] rx_data;
   logic       ibf, intr, inte;
   logic [7:0] status;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   strb_in_chan #(.WIDTH(8), .SYNC_STAGES(2), .CHAN_B(0)) uut (
      .clk(clk), .rst(rst), .stb_n(stb_n), .pins(pins), .host_rd(host_rd),
      .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_val(bsr_val),
      .rx_data(rx_data), .ibf(ibf), .intr(intr), .inte(inte), .status(status)
   );

   // bit 8 = enable setting, bits 7:0 = byte on the pins
   localparam logic [8:0] VECS [6] = '{
      9'h1A5, 9'h05A, 9'h1FF, 9'h000, 9'h13C, 9'h081
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // channel A layout from R9
   function automatic logic [7:0] stat_a(input logic f, input logic e, input logic q);
      return {2'b00, f, e, q, 3'b000};
   endfunction

   task automatic bsr(input logic [2:0] sel, input logic val);
      bsr_we = 1'b1; bsr_sel = sel; bsr_val = val;
      tick(1);
      bsr_we = 1'b0;
   endtask

   task automatic read_port();
      host_rd = 1'b1;
      tick(1);
      host_rd = 1'b0;
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      tick(3);
      // R1: state during reset
      check("R1 ibf in reset", ibf, 0);
      check("R1 status in reset", status, 0);
      rst = 1'b0;
      tick(2);
      check("R1 data after reset", rx_data, 0);
      check("R1 intr/inte after reset", {intr, inte}, 0);

      foreach (VECS[i]) begin
         logic [7:0] b;
         logic en;
         b  = VECS[i][7:0];
         en = VECS[i][8];
         bsr(3'd4, en);
         check("R7 enable via bit 4", inte, en);
         pins = b; stb_n = 1'b0;
         tick(2);
         check("R3 ibf not early", ibf, 0);
         tick(1);
         check("R2 capture data", rx_data, b);
         check("R3 ibf with data", ibf, 1);
         check("R9 status full", status, stat_a(1'b1, en, 1'b0));
         stb_n = 1'b1;
         tick(2);
         check("R4 intr not early", intr, 0);
         tick(1);
         check(en ? "R4 intr after strobe" : "R5 intr gated", intr, en);
         check("R9 status irq", status, stat_a(1'b1, en, en));
         read_port();
         check("R6 read clears", {ibf, intr}, 0);
         check("R6 data kept", rx_data, b);
      end

      // R7: other bit numbers leave the enable unchanged
      bsr(3'd4, 1'b1);
      bsr(3'd2, 1'b0);
      check("R7 bit 2 ignored", inte, 1);
      bsr(3'd5, 1'b0);
      check("R7 bit 5 ignored", status, stat_a(1'b0, 1'b1, 1'b0));

      // R8: strobe while full reloads
      pins = 8'h11; stb_n = 1'b0; tick(3);
      stb_n = 1'b1; tick(3);
      pins = 8'h22; stb_n = 1'b0; tick(3);
      check("R8 reload data", rx_data, 8'h22);
      check("R8 ibf stays", ibf, 1);

      // R11: pins change while strobe held low, then held high
      pins = 8'h33; tick(4);
      check("R11 low hold", rx_data, 8'h22);
      stb_n = 1'b1; tick(3);
      pins = 8'h44; tick(4);
      check("R11 high hold", rx_data, 8'h22);
      read_port();

      // R10: read on the capture edge
      pins = 8'h55; stb_n = 1'b0; tick(2);
      host_rd = 1'b1; tick(1); host_rd = 1'b0;
      check("R10 capture wins ibf", ibf, 1);
      check("R10 capture wins data", rx_data, 8'h55);
      stb_n = 1'b1; tick(3);

      // R1: reset mid-run
      rst = 1'b1; tick(2); rst = 1'b0; tick(1);
      check("R1 reset clears all", {rx_data, ibf, intr, inte}, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule